// File: doc/BRIEF.md
# Configuration Register Safety Supervisor

This block holds the configuration word of a cell monitoring device and guards it with two protections. An inactivity watchdog counts system clock cycles between serial clock activity strobes. When the count reaches a programmable limit, it drives an active-low flag and reloads the configuration with its default value. A configuration bit chosen by a parameter enables the watchdog. Because the default value has that bit set, the watchdog runs out of reset.

The second protection watches a digital die-temperature code while the device is out of standby. If the code rises above a trip value, the block takes three actions:
- it reloads the default configuration, which turns off every discharge bit and stops conversions;
- it sets a sticky shutdown status bit;
- it raises an interface-block output.

The interface-block output stays high until the code falls through a hysteresis band, or until standby is entered. Configuration writes that arrive while this output is high are dropped. The status bit clears only on a temperature-register read strobe.

Top module: `cfg_guard`

## Requirements
- R1: With cfg_q[WDT_BIT] = 1, wdt_n goes low after TIMEOUT consecutive clock cycles in which sck_evt is low. The last sck_evt, or reset, starts the count.
- R2: In the cycle wdt_n falls, cfg_q equals DEFAULT_CFG. A timeout takes priority over a write in the same cycle.
- R3: While cfg_q[WDT_BIT] = 0, wdt_n never falls and the inactivity count is held at zero. After the bit is set again, a full TIMEOUT window is needed before wdt_n can fall.
- R4: A cycle with sck_evt high makes wdt_n high on the next cycle and restarts the inactivity count.
- R5: In a cycle where standby is low, if_block is low and temp_code > TRIP_CODE, the next cycle shows if_block = 1, thsd = 1 and cfg_q = DEFAULT_CFG.
- R6: Once high, if_block stays high while temp_code > TRIP_CODE - HYST. It drops on the cycle after temp_code <= TRIP_CODE - HYST or standby is high.
- R7: thsd sets on every trip. It clears on the cycle after tmp_rd is high. A trip in the same cycle as tmp_rd wins.
- R8: A wr_en cycle loads wr_data into cfg_q on the next cycle. The write is ignored when if_block is high, in a trip cycle, or in a timeout cycle.
- R9: With standby high, no trip occurs and if_block is low on the next cycle.
- R10: After reset: cfg_q = DEFAULT_CFG, wdt_n = 1, thsd = 0, if_block = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_evt | input | 1 | One-cycle strobe per detected serial clock edge |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | CFG_W | Configuration write data |
| temp_code | input | TEMP_W | Die temperature code, larger is hotter |
| standby | input | 1 | Device is in standby; thermal monitoring off |
| tmp_rd | input | 1 | Temperature register read strobe |
| cfg_q | output | CFG_W | Configuration register contents |
| wdt_n | output | 1 | Watchdog flag, low after timeout |
| thsd | output | 1 | Sticky thermal shutdown status |
| if_block | output | 1 | Serial interface held inactive |

## Verification
The bench builds the block with a 16-bit configuration word whose enable bit is bit 3. It uses a 40-cycle timeout, a 10-bit temperature code with trip value 600, and a hysteresis of 20.

The short timeout lets sparse-activity phases produce many watchdog expiries. Some of these expiries coincide with writes and with re-enabling. Random temperature codes near 580 and 600 exercise the edges of the hysteresis band. Random read and standby strobes in the same window collide with trips.

// File: rtl/cfg_guard.sv
module cfg_guard #(
  parameter int CFG_W = 8,
  parameter int WDT_BIT = 7,
  parameter logic [CFG_W-1:0] DEFAULT_CFG = 8'h80,
  parameter int TIMEOUT = 20_000_000,
  parameter int TEMP_W = 10,
  parameter logic [TEMP_W-1:0] TRIP_CODE = 10'd580,
  parameter logic [TEMP_W-1:0] HYST = 10'd16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_evt,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              standby,
  input  logic              tmp_rd,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              wdt_n,
  output logic              thsd,
  output logic              if_block
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
  localparam logic [TEMP_W-1:0] COOL_CODE = TRIP_CODE - HYST;

  logic [CW-1:0] cnt;

  wire wdt_en  = cfg_q[WDT_BIT];
  wire timeout = wdt_en && wdt_n && !sck_evt && (cnt == LAST);
  wire trip    = !standby && !if_block && (temp_code > TRIP_CODE);
  wire cooled  = temp_code <= COOL_CODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (sck_evt || !wdt_en || !wdt_n || timeout)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wdt_n <= 1'b1;
    else if (sck_evt)
      wdt_n <= 1'b1;
    else if (timeout)
      wdt_n <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      if_block <= 1'b0;
    else if (standby)
      if_block <= 1'b0;
    else if (trip)
      if_block <= 1'b1;
    else if (cooled)
      if_block <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      thsd <= 1'b0;
    else if (trip)
      thsd <= 1'b1;
    else if (tmp_rd)
      thsd <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= DEFAULT_CFG;
    else if (trip || timeout)
      cfg_q <= DEFAULT_CFG;
    else if (wr_en && !if_block)
      cfg_q <= wr_data;
  end

endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int CFG_W = 8,
  parameter int WDT_BIT = 7,
  parameter logic [CFG_W-1:0] DEFAULT_CFG = 8'h80,
  parameter int TEMP_W = 10,
  parameter logic [TEMP_W-1:0] TRIP_CODE = 10'd580,
  parameter logic [TEMP_W-1:0] HYST = 10'd16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck_evt,
  input logic              wr_en,
  input logic [CFG_W-1:0]  wr_data,
  input logic [TEMP_W-1:0] temp_code,
  input logic              standby,
  input logic              tmp_rd,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              wdt_n,
  input logic              thsd,
  input logic              if_block
);

  localparam logic [TEMP_W-1:0] COOL_CODE = TRIP_CODE - HYST;
  wire hot_now = !standby && !if_block && (temp_code > TRIP_CODE);

  p_fall_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_n) |-> cfg_q == DEFAULT_CFG);

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[WDT_BIT] |=> !$fell(wdt_n));

  p_evt_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck_evt |=> wdt_n);

  p_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hot_now |=> (if_block && thsd && cfg_q == DEFAULT_CFG));

  p_hyst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (if_block && !standby && temp_code > COOL_CODE) |=> if_block);

  p_thsd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmp_rd && !hot_now) |=> !thsd);

  p_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && if_block) |=> $stable(cfg_q));

  p_wr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sck_evt && !if_block && !hot_now) |=> cfg_q == $past(wr_data));

  p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !if_block);

endmodule

bind cfg_guard cfg_guard_chk #(
  .CFG_W(CFG_W), .WDT_BIT(WDT_BIT), .DEFAULT_CFG(DEFAULT_CFG),
  .TEMP_W(TEMP_W), .TRIP_CODE(TRIP_CODE), .HYST(HYST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_evt(sck_evt), .wr_en(wr_en), .wr_data(wr_data),
  .temp_code(temp_code), .standby(standby), .tmp_rd(tmp_rd), .cfg_q(cfg_q),
  .wdt_n(wdt_n), .thsd(thsd), .if_block(if_block)
);

// File: tb/cfg_guard_tb.sv
`timescale 1ns/1ps
module cfg_guard_tb;
  localparam int CFG_W = 16;
  localparam int WDT_BIT = 3;
  localparam logic [CFG_W-1:0] DEF = 16'h0008;
  localparam int TMO = 40;
  localparam int TEMP_W = 10;
  localparam logic [TEMP_W-1:0] TRIP = 10'd600;
  localparam logic [TEMP_W-1:0] HYS = 10'd20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck_evt = 1'b0, wr_en = 1'b0, standby = 1'b0, tmp_rd = 1'b0;
  logic [CFG_W-1:0] wr_data = '0;
  logic [TEMP_W-1:0] temp_code = 10'd300;
  logic [CFG_W-1:0] cfg_q;
  logic wdt_n, thsd, if_block;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [CFG_W-1:0] m_cfg;
  logic m_wdt, m_thsd, m_hot;
  int m_idle;

  always #5 clk = ~clk;

  cfg_guard #(.CFG_W(CFG_W), .WDT_BIT(WDT_BIT), .DEFAULT_CFG(DEF), .TIMEOUT(TMO),
              .TEMP_W(TEMP_W), .TRIP_CODE(TRIP), .HYST(HYS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck_evt(sck_evt), .wr_en(wr_en), .wr_data(wr_data),
    .temp_code(temp_code), .standby(standby), .tmp_rd(tmp_rd), .cfg_q(cfg_q),
    .wdt_n(wdt_n), .thsd(thsd), .if_block(if_block));

  function automatic bit f_trip(logic sb, logic hot, logic [TEMP_W-1:0] t);
    return !sb && !hot && (t > TRIP);
  endfunction

  function automatic bit f_expire(logic [CFG_W-1:0] c, logic w, int idle, logic evt);
    return c[WDT_BIT] && w && !evt && (idle == TMO - 1);
  endfunction

  task automatic model_reset();
    m_cfg = DEF; m_wdt = 1'b1; m_thsd = 1'b0; m_hot = 1'b0; m_idle = 0;
  endtask

  task automatic model_step();
    bit tr, ex;
    tr = f_trip(standby, m_hot, temp_code);
    ex = f_expire(m_cfg, m_wdt, m_idle, sck_evt);
    if (tr || ex) m_cfg = DEF;
    else if (wr_en && !m_hot) m_cfg = wr_data;
    if (sck_evt || !m_wdt || ex || !(tr || ex ? DEF[WDT_BIT] : 1'b1)) m_idle = 0;
    if (sck_evt) m_wdt = 1'b1; else if (ex) m_wdt = 1'b0;
    if (tr) m_thsd = 1'b1; else if (tmp_rd) m_thsd = 1'b0;
    if (standby) m_hot = 1'b0;
    else if (tr) m_hot = 1'b1;
    else if (temp_code <= TRIP - HYS) m_hot = 1'b0;
  endtask

  logic [CFG_W-1:0] pre_cfg;
  logic pre_wdt;
  logic pre_evt;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 R5 R8 cfg_q", 32'(cfg_q), 32'(m_cfg));
    chk("R1 R3 R4 wdt_n", 32'(wdt_n), 32'(m_wdt));
    chk("R7 thsd", 32'(thsd), 32'(m_thsd));
    chk("R6 R9 if_block", 32'(if_block), 32'(m_hot));
  endtask

  task automatic cycle();
    pre_cfg = m_cfg; pre_wdt = m_wdt; pre_evt = sck_evt;
    @(posedge clk);
    model_step();
    if (pre_evt || !pre_cfg[WDT_BIT] || !pre_wdt) m_idle = 0;
    else if (m_wdt) m_idle = m_idle + 1;
    @(negedge clk);
    check_all();
    sck_evt = 1'b0; wr_en = 1'b0; tmp_rd = 1'b0;
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset cfg_q", 32'(cfg_q), 32'(DEF));
    chk("R10 reset wdt_n", 32'(wdt_n), 32'd1);
    chk("R10 reset thsd", 32'(thsd), 32'd0);
    chk("R10 reset if_block", 32'(if_block), 32'd0);

    // R1/R2: write a value, then stay silent until the watchdog expires
    sck_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h5A5F; cycle();
    idle_cycles(TMO - 1);
    chk("R1 no early timeout", 32'(wdt_n), 32'd1);
    idle_cycles(1);
    chk("R1 timeout wdt_n", 32'(wdt_n), 32'd0);
    chk("R2 timeout cfg default", 32'(cfg_q), 32'(DEF));
    // R4: activity releases the flag
    sck_evt = 1'b1; cycle();
    chk("R4 release wdt_n", 32'(wdt_n), 32'd1);

    // R3: disable the watchdog, wait long, re-enable, need a full window
    sck_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h1230; cycle();
    idle_cycles(3 * TMO);
    chk("R3 disabled no timeout", 32'(wdt_n), 32'd1);
    wr_en = 1'b1; wr_data = 16'h1238; cycle();
    idle_cycles(TMO - 2);
    chk("R3 full window after enable", 32'(wdt_n), 32'd1);
    idle_cycles(2);
    chk("R3 expires after re-enable", 32'(wdt_n), 32'd0);
    sck_evt = 1'b1; cycle();

    // R5/R7/R8: trip, blocked write, hysteresis, read clear
    sck_evt = 1'b1; wr_en = 1'b1; wr_data = 16'hFFFF; cycle();
    temp_code = TRIP + 1; sck_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h0F0F; cycle();
    chk("R5 trip block", 32'(if_block), 32'd1);
    chk("R8 trip-cycle write ignored", 32'(cfg_q), 32'(DEF));
    temp_code = TRIP - HYS + 1; sck_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h7777; cycle();
    chk("R8 write while blocked ignored", 32'(cfg_q), 32'(DEF));
    chk("R6 held in band", 32'(if_block), 32'd1);
    tmp_rd = 1'b1; sck_evt = 1'b1; cycle();
    chk("R7 read clears thsd", 32'(thsd), 32'd0);
    temp_code = TRIP - HYS; sck_evt = 1'b1; cycle();
    chk("R6 release at band floor", 32'(if_block), 32'd0);
    // R7: trip wins over read
    temp_code = TRIP + 5; tmp_rd = 1'b1; sck_evt = 1'b1; cycle();
    chk("R7 trip wins over read", 32'(thsd), 32'd1);
    // R9: standby drops block and prevents trip
    standby = 1'b1; sck_evt = 1'b1; cycle();
    chk("R9 standby clears block", 32'(if_block), 32'd0);
    sck_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h4448; cycle();
    chk("R9 no trip in standby", 32'(cfg_q), 32'h4448);
    standby = 1'b0; temp_code = 10'd300; sck_evt = 1'b1; cycle();

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      for (int i = 0; i < 800; i++) begin
        int den;
        den = (ph % 2 == 0) ? 4 : 70;
        sck_evt = ($urandom % den) == 0;
        wr_en = sck_evt && (($urandom % 4) == 0);
        wr_data = 16'($urandom);
        tmp_rd = ($urandom % 12) == 0;
        standby = ($urandom % 40) == 0;
        temp_code = (ph < 4) ? 10'(560 + ($urandom % 70)) : 10'(200 + ($urandom % 300));
        cycle();
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule